// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block sits between a conditioned PWM command and the two gate enables of a synchronous buck power stage. It turns the PWM level into a high-side enable (`gh_o`) and a low-side enable (`gl_o`). Each edge has its own programmable delay, counted in clock cycles. The dead time is adaptive: when the high side switches off, the low side does not start its turn-on timer until a comparator bit reports that the high-side gate voltage has dropped below its off threshold. After that timer expires, the low side turns on without looking at the switch node, so the stage can still sink current.

Several conditions force both enables low:
- a tri-state flag on the PWM command;
- an active-low stage disable, which is filtered in both directions;
- an undervoltage flag on the logic supply or on the boot supply.

A separate active-low inhibit holds the low side off while the high side keeps following PWM. When a shutdown ends, the sequencer always restarts on the low-side path and takes the adaptive dead time again. An upstream conditioner is expected to resolve a floating disable pin to low and a floating inhibit pin to high. All delay parameters must be at least 1.

Top module: `gdrv_halfbridge_seq`

## Requirements
- R1: With PWM held low and no shutdown, `gl_o`=1 and `gh_o`=0; with PWM held high, `gh_o`=1 and `gl_o`=0.
- R2: `gh_o` and `gl_o` are never 1 in the same cycle.
- R3: When PWM rises from the low-side state, `gl_o` falls at the GL_OFF_CYC-th clock edge after the first edge that samples PWM high. `gh_o` then rises GH_ON_CYC edges later, so GL is always seen low for at least one cycle before GH rises.
- R4: When PWM falls from the high-side state, `gh_o` falls GH_OFF_CYC edges after the first edge that samples PWM low. `gl_o` stays low until an edge samples `hs_gate_low_i`=1. It rises GL_ON_CYC edges after that edge, with no further check of `hs_gate_low_i`.
- R5: If PWM reverses before a pending turn-off delay expires, that transition is cancelled and the output that was on stays on without a glitch.
- R6: `pwm_tri_i`=1 forces both outputs low from the first edge that samples it. After it clears, the shutdown is held for TRI_EXIT_CYC more edges.
- R7: `dis_n_i`=0 must be sampled on DIS_CYC consecutive edges before both outputs go low, which happens on the edge after that. Re-enabling after `dis_n_i`=1 follows the same count.
- R8: `vcc_uv_i`=1 or `boot_uv_i`=1 forces both outputs low from the first edge that samples it.
- R9: `ls_inh_n_i`=0 forces `gl_o` low from the next edge, while `gh_o` keeps the R3/R4 timing.
- R10: Reset holds both outputs low. When reset or any shutdown ends, the sequencer restarts in the wait-for-high-side-off phase. With PWM low, `gl_o` rises 1+GL_ON_CYC edges after the first edge with no shutdown, provided `hs_gate_low_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | Conditioned PWM level (1 = high side on) |
| pwm_tri_i | input | 1 | PWM command is in its tri-state window |
| dis_n_i | input | 1 | Active-low stage disable (floating resolved low upstream) |
| ls_inh_n_i | input | 1 | Active-low low-side inhibit |
| vcc_uv_i | input | 1 | Logic supply undervoltage flag |
| boot_uv_i | input | 1 | Boot supply undervoltage flag |
| hs_gate_low_i | input | 1 | High-side gate voltage is below its off threshold |
| gh_o | output | 1 | High-side gate enable |
| gl_o | output | 1 | Low-side gate enable |

## Verification
Directed sequences hold PWM steady, step it once in each direction, and reverse it in the middle of a turn-off delay. Together they separate the per-edge delays from the cancel behaviour and show the adaptive wait, because `hs_gate_low_i` is held low on purpose for several cycles. Each shutdown source is applied once while the stage is driving and once during a PWM change, and is then released. This separates the zero-delay sources (tri-state, undervoltage) from the filtered disable and from the restart path. A long random phase changes PWM, the shutdown flags, the inhibit and the comparator bit together, and compares the outputs every cycle with a bench-side cycle model. This exposes interactions between a cancel and a shutdown that the directed cases do not reach.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

  typedef enum logic [2:0] {
    PH_HALT      = 3'd0,
    PH_LOW       = 3'd1,
    PH_LOW_EXIT  = 3'd2,
    PH_GAP_UP    = 3'd3,
    PH_HIGH      = 3'd4,
    PH_HIGH_EXIT = 3'd5,
    PH_WAIT_OFF  = 3'd6,
    PH_GAP_DN    = 3'd7
  } phase_e;

  // A delay of dly edges has expired when the running count reaches dly-1.
  function automatic logic tmr_hit(input int unsigned cnt, input int unsigned dly);
    return (cnt + 1) >= dly;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic gh_of(input phase_e ph);
    return (ph == PH_HIGH) || (ph == PH_HIGH_EXIT);
  endfunction

  function automatic logic gl_of(input phase_e ph);
    return (ph == PH_LOW) || (ph == PH_LOW_EXIT);
  endfunction

endpackage

// File: rtl/gdrv_lvl_filter.sv
module gdrv_lvl_filter
  import gdrv_pkg::*;
#(
  parameter int unsigned D_RISE  = 4,
  parameter int unsigned D_FALL  = 4,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_i,
  output logic out_o
);
  localparam int unsigned DMAX = max2(D_RISE, D_FALL);
  localparam int unsigned CW   = $clog2(DMAX + 1);

  logic          out_q;
  logic [CW-1:0] cnt_q;
  logic          differ;
  logic          hit;

  assign differ = (in_i != out_q);
  assign hit    = tmr_hit(32'(cnt_q), out_q ? D_FALL : D_RISE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= RST_VAL;
      cnt_q <= '0;
    end else if (differ) begin
      if (hit) begin
        out_q <= in_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign out_o = out_q;

  // R7: the filtered level only ever moves towards the sampled input.
  a_r7_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> (out_q == $past(in_i)));

endmodule

// File: rtl/gdrv_qualify.sv
module gdrv_qualify #(
  parameter int unsigned TRI_EXIT_CYC = 3,
  parameter int unsigned DIS_CYC      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_tri_i,
  input  logic dis_n_i,
  input  logic ls_inh_n_i,
  input  logic vcc_uv_i,
  input  logic boot_uv_i,
  output logic halt_o,
  output logic ls_en_o
);
  logic en_q;
  logic tri_hold;
  logic ls_en_q;

  // Disable: symmetric filter, reset state is "disabled".
  gdrv_lvl_filter #(.D_RISE(DIS_CYC), .D_FALL(DIS_CYC), .RST_VAL(1'b0)) u_dis_flt (
    .clk   (clk),
    .rst_n (rst_n),
    .in_i  (dis_n_i),
    .out_o (en_q)
  );

  // Tri-state: immediate entry, held exit.
  gdrv_lvl_filter #(.D_RISE(1), .D_FALL(TRI_EXIT_CYC), .RST_VAL(1'b0)) u_tri_flt (
    .clk   (clk),
    .rst_n (rst_n),
    .in_i  (pwm_tri_i),
    .out_o (tri_hold)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ls_en_q <= 1'b0;
    else        ls_en_q <= ls_inh_n_i;
  end

  assign halt_o  = vcc_uv_i | boot_uv_i | pwm_tri_i | tri_hold | ~en_q;
  assign ls_en_o = ls_en_q;

  // R6: a raw tri-state request always stops the sequencer.
  a_r6_tri_halts: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_tri_i |-> halt_o);

endmodule

// File: rtl/gdrv_phase_fsm.sv
module gdrv_phase_fsm
  import gdrv_pkg::*;
#(
  parameter int unsigned GL_OFF_CYC = 2,
  parameter int unsigned GH_ON_CYC  = 3,
  parameter int unsigned GH_OFF_CYC = 4,
  parameter int unsigned GL_ON_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_i,
  input  logic hs_gate_low_i,
  input  logic halt_i,
  output logic gh_cmd_o,
  output logic gl_cmd_o
);
  localparam int unsigned DMAX = max2(max2(GL_OFF_CYC, GH_ON_CYC), max2(GH_OFF_CYC, GL_ON_CYC));
  localparam int unsigned CW   = $clog2(DMAX + 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] cnt_inc;

  // Named events for the checks below.
  logic ev_gl_off_done, ev_gh_on_done, ev_gh_off_done, ev_gl_on_done;

  assign cnt_inc        = cnt_q + 1'b1;
  assign ev_gl_off_done = tmr_hit(32'(cnt_q), GL_OFF_CYC);
  assign ev_gh_on_done  = tmr_hit(32'(cnt_q), GH_ON_CYC);
  assign ev_gh_off_done = tmr_hit(32'(cnt_q), GH_OFF_CYC);
  assign ev_gl_on_done  = tmr_hit(32'(cnt_q), GL_ON_CYC);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = '0;
    if (halt_i) begin
      ph_d = PH_HALT;
    end else begin
      case (ph_q)
        PH_HALT:      ph_d = PH_WAIT_OFF;
        PH_LOW:       if (pwm_i) ph_d = PH_LOW_EXIT;
        PH_LOW_EXIT: begin
          if (!pwm_i)              ph_d = PH_LOW;
          else if (ev_gl_off_done) ph_d = PH_GAP_UP;
          else                     cnt_d = cnt_inc;
        end
        PH_GAP_UP: begin
          if (!pwm_i)              ph_d = PH_WAIT_OFF;
          else if (ev_gh_on_done)  ph_d = PH_HIGH;
          else                     cnt_d = cnt_inc;
        end
        PH_HIGH:      if (!pwm_i) ph_d = PH_HIGH_EXIT;
        PH_HIGH_EXIT: begin
          if (pwm_i)               ph_d = PH_HIGH;
          else if (ev_gh_off_done) ph_d = PH_WAIT_OFF;
          else                     cnt_d = cnt_inc;
        end
        PH_WAIT_OFF: begin
          if (pwm_i)               ph_d = PH_GAP_UP;
          else if (hs_gate_low_i)  ph_d = PH_GAP_DN;
        end
        PH_GAP_DN: begin
          if (pwm_i)               ph_d = PH_GAP_UP;
          else if (ev_gl_on_done)  ph_d = PH_LOW;
          else                     cnt_d = cnt_inc;
        end
        default:                   ph_d = PH_HALT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_HALT;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign gh_cmd_o = gh_of(ph_q);
  assign gl_cmd_o = gl_of(ph_q);

  // R4: the low side only comes on at the end of the adaptive dead time.
  a_r4_gl_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gl_cmd_o) |-> $past(ph_q == PH_GAP_DN));

  // R5: a reversal during the low-side turn-off delay keeps the low side on.
  a_r5_low_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_LOW_EXIT && !pwm_i && !halt_i) |=> gl_cmd_o);

  // R10: leaving a shutdown always enters the wait-for-high-side-off phase.
  a_r10_restart_path: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HALT && !halt_i) |=> (ph_q == PH_WAIT_OFF));

endmodule

// File: rtl/gdrv_halfbridge_seq.sv
module gdrv_halfbridge_seq #(
  parameter int unsigned GL_OFF_CYC   = 2,
  parameter int unsigned GH_ON_CYC    = 3,
  parameter int unsigned GH_OFF_CYC   = 4,
  parameter int unsigned GL_ON_CYC    = 4,
  parameter int unsigned TRI_EXIT_CYC = 3,
  parameter int unsigned DIS_CYC      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_i,
  input  logic pwm_tri_i,
  input  logic dis_n_i,
  input  logic ls_inh_n_i,
  input  logic vcc_uv_i,
  input  logic boot_uv_i,
  input  logic hs_gate_low_i,
  output logic gh_o,
  output logic gl_o
);
  logic halt;
  logic ls_en;
  logic gh_cmd;
  logic gl_cmd;

  gdrv_qualify #(.TRI_EXIT_CYC(TRI_EXIT_CYC), .DIS_CYC(DIS_CYC)) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_tri_i  (pwm_tri_i),
    .dis_n_i    (dis_n_i),
    .ls_inh_n_i (ls_inh_n_i),
    .vcc_uv_i   (vcc_uv_i),
    .boot_uv_i  (boot_uv_i),
    .halt_o     (halt),
    .ls_en_o    (ls_en)
  );

  gdrv_phase_fsm #(
    .GL_OFF_CYC (GL_OFF_CYC),
    .GH_ON_CYC  (GH_ON_CYC),
    .GH_OFF_CYC (GH_OFF_CYC),
    .GL_ON_CYC  (GL_ON_CYC)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwm_i         (pwm_i),
    .hs_gate_low_i (hs_gate_low_i),
    .halt_i        (halt),
    .gh_cmd_o      (gh_cmd),
    .gl_cmd_o      (gl_cmd)
  );

  assign gh_o = gh_cmd;
  assign gl_o = gl_cmd & ls_en;

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(gh_o && gl_o));

  a_r3_gl_low_before_gh: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gh_o) |-> $past(!gl_o));

  a_r8_uv_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_uv_i || boot_uv_i) |=> (!gh_o && !gl_o));

  a_r6_tri_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_tri_i |=> (!gh_o && !gl_o));

  a_r9_inhibit_gl: assert property (@(posedge clk) disable iff (!rst_n)
    !ls_inh_n_i |=> !gl_o);

endmodule

// File: tb/gdrv_halfbridge_seq_tb.sv
`timescale 1ns/1ps
module gdrv_halfbridge_seq_tb;
  localparam int P_GL_OFF = 2;
  localparam int P_GH_ON  = 3;
  localparam int P_GH_OFF = 4;
  localparam int P_GL_ON  = 4;
  localparam int P_TS     = 3;
  localparam int P_DIS    = 4;

  localparam int M_HALT = 0, M_LOW = 1, M_LOWX = 2, M_UP = 3,
                 M_HIGH = 4, M_HIGHX = 5, M_WAIT = 6, M_DN = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 1'b0, tri_s = 1'b0, dis_n = 1'b1, inh_n = 1'b1;
  logic vuv = 1'b0, buv = 1'b0, hs_low = 1'b1;
  logic gh, gl;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R10";

  always #2 clk = ~clk;

  gdrv_halfbridge_seq #(
    .GL_OFF_CYC(P_GL_OFF), .GH_ON_CYC(P_GH_ON), .GH_OFF_CYC(P_GH_OFF),
    .GL_ON_CYC(P_GL_ON), .TRI_EXIT_CYC(P_TS), .DIS_CYC(P_DIS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .pwm_tri_i(tri_s), .dis_n_i(dis_n),
    .ls_inh_n_i(inh_n), .vcc_uv_i(vuv), .boot_uv_i(buv), .hs_gate_low_i(hs_low),
    .gh_o(gh), .gl_o(gl)
  );

  // Bench cycle model, built from the requirement timings.
  int m_ph = M_HALT, m_cnt = 0, m_encnt = 0, m_tricnt = 0;
  bit m_enq = 0, m_triq = 0, m_lsq = 0, m_halt = 0;
  int nph, ncnt;

  function automatic bit due(input int cnt, input int dly);
    return cnt >= dly - 1;
  endfunction

  function automatic bit exp_gh();
    return (m_ph == M_HIGH) || (m_ph == M_HIGHX);
  endfunction

  function automatic bit exp_gl();
    return ((m_ph == M_LOW) || (m_ph == M_LOWX)) && m_lsq;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = M_HALT; m_cnt = 0; m_enq = 0; m_encnt = 0;
      m_triq = 0; m_tricnt = 0; m_lsq = 0;
    end else begin
      m_halt = vuv || buv || tri_s || m_triq || !m_enq;
      nph = m_ph; ncnt = 0;
      if (m_halt) nph = M_HALT;
      else begin
        case (m_ph)
          M_HALT:  nph = M_WAIT;
          M_LOW:   if (pwm) nph = M_LOWX;
          M_LOWX:  if (!pwm) nph = M_LOW; else if (due(m_cnt, P_GL_OFF)) nph = M_UP; else ncnt = m_cnt + 1;
          M_UP:    if (!pwm) nph = M_WAIT; else if (due(m_cnt, P_GH_ON)) nph = M_HIGH; else ncnt = m_cnt + 1;
          M_HIGH:  if (!pwm) nph = M_HIGHX;
          M_HIGHX: if (pwm) nph = M_HIGH; else if (due(m_cnt, P_GH_OFF)) nph = M_WAIT; else ncnt = m_cnt + 1;
          M_WAIT:  if (pwm) nph = M_UP; else if (hs_low) nph = M_DN;
          default: if (pwm) nph = M_UP; else if (due(m_cnt, P_GL_ON)) nph = M_LOW; else ncnt = m_cnt + 1;
        endcase
      end
      if (dis_n != m_enq) begin
        if (due(m_encnt, P_DIS)) begin m_enq = dis_n; m_encnt = 0; end
        else m_encnt = m_encnt + 1;
      end else m_encnt = 0;
      if (tri_s != m_triq) begin
        if (due(m_tricnt, m_triq ? P_TS : 1)) begin m_triq = tri_s; m_tricnt = 0; end
        else m_tricnt = m_tricnt + 1;
      end else m_tricnt = 0;
      m_lsq = inh_n;
      m_ph = nph; m_cnt = ncnt;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk(cur_req, gh, exp_gh(), "gh vs model");
    chk(cur_req, gl, exp_gl(), "gl vs model");
    chk("R2", gh & gl, 1'b0, "overlap");
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic baseline();
    pwm = 0; tri_s = 0; dis_n = 1; inh_n = 1; vuv = 0; buv = 0; hs_low = 1;
    ticks(20);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R10: reset holds both low
    ticks(3);
    chk("R10", gh, 1'b0, "gh in reset");
    chk("R10", gl, 1'b0, "gl in reset");
    rst_n = 1;
    ticks(20);
    chk("R10", gl, 1'b1, "gl after restart");
    chk("R1", gh, 1'b0, "gh steady low pwm");

    // R3: rising PWM
    cur_req = "R3";
    pwm = 1; ticks(2);
    chk("R3", gl, 1'b1, "gl before GL_OFF delay");
    tick();
    chk("R3", gl, 1'b0, "gl after GL_OFF delay");
    chk("R3", gh, 1'b0, "gh in gap");
    ticks(2);
    chk("R3", gh, 1'b0, "gh before GH_ON delay");
    tick();
    chk("R3", gh, 1'b1, "gh after GH_ON delay");
    hs_low = 0; ticks(4);
    chk("R1", gh, 1'b1, "gh steady high pwm");
    chk("R1", gl, 1'b0, "gl steady high pwm");

    // R4: falling PWM with adaptive wait
    cur_req = "R4";
    pwm = 0; ticks(4);
    chk("R4", gh, 1'b1, "gh before GH_OFF delay");
    tick();
    chk("R4", gh, 1'b0, "gh after GH_OFF delay");
    ticks(3);
    chk("R4", gl, 1'b0, "gl waits for hs off");
    hs_low = 1; ticks(4);
    chk("R4", gl, 1'b0, "gl before GL_ON delay");
    tick();
    chk("R4", gl, 1'b1, "gl after GL_ON delay");

    // R5: cancel on low side, then on high side
    cur_req = "R5";
    ticks(4);
    pwm = 1; tick(); pwm = 0;
    for (int i = 0; i < 6; i++) begin tick(); chk("R5", gl, 1'b1, "gl kept on cancel"); end
    pwm = 1; ticks(8); hs_low = 0;
    chk("R5", gh, 1'b1, "gh on before cancel");
    pwm = 0; ticks(2); pwm = 1;
    for (int i = 0; i < 6; i++) begin tick(); chk("R5", gh, 1'b1, "gh kept on cancel"); end
    pwm = 0; ticks(6); hs_low = 1; ticks(8);

    // R7: disable filtering
    cur_req = "R7";
    baseline();
    dis_n = 0; ticks(4);
    chk("R7", gl, 1'b1, "gl before disable count");
    tick();
    chk("R7", gl, 1'b0, "gl after disable count");
    pwm = 1; ticks(5);
    chk("R7", gh, 1'b0, "gh while disabled");
    pwm = 0; ticks(2);
    dis_n = 1; ticks(9);
    chk("R7", gl, 1'b0, "gl before re-enable path");
    tick();
    chk("R7", gl, 1'b1, "gl after re-enable path");

    // R6: tri-state
    cur_req = "R6";
    baseline();
    tri_s = 1; tick();
    chk("R6", gl, 1'b0, "gl on tri entry");
    pwm = 1; ticks(3);
    chk("R6", gh, 1'b0, "gh during tri");
    pwm = 0; ticks(2);
    tri_s = 0; ticks(8);
    chk("R6", gl, 1'b0, "gl before tri exit path");
    tick();
    chk("R6", gl, 1'b1, "gl after tri exit path");

    // R8: undervoltage
    cur_req = "R8";
    baseline();
    pwm = 1; ticks(8); hs_low = 0;
    chk("R8", gh, 1'b1, "gh before vcc uv");
    vuv = 1; tick();
    chk("R8", gh, 1'b0, "gh on vcc uv");
    pwm = 0; hs_low = 1; ticks(3);
    vuv = 0; ticks(5);
    chk("R8", gl, 1'b0, "gl before uv restart");
    tick();
    chk("R8", gl, 1'b1, "gl after uv restart");
    buv = 1; tick();
    chk("R8", gl, 1'b0, "gl on boot uv");
    buv = 0; ticks(8);

    // R9: low-side inhibit
    cur_req = "R9";
    baseline();
    inh_n = 0; tick();
    chk("R9", gl, 1'b0, "gl inhibited");
    pwm = 1; ticks(5);
    chk("R9", gh, 1'b0, "gh before GH_ON under inhibit");
    tick();
    chk("R9", gh, 1'b1, "gh follows pwm under inhibit");
    pwm = 0; ticks(12);
    chk("R9", gl, 1'b0, "gl still inhibited");
    inh_n = 1; tick();
    chk("R9", gl, 1'b1, "gl after inhibit release");

    // Random phase, model compared every cycle
    cur_req = "R1";
    baseline();
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 6 == 0) pwm = ~pwm;
      if (tri_s) begin if ($urandom % 4 == 0) tri_s = 0; end
      else if ($urandom % 200 == 0) tri_s = 1;
      vuv = ($urandom % 300 == 0);
      buv = ($urandom % 300 == 0);
      if (!dis_n) begin if ($urandom % 10 == 0) dis_n = 1; end
      else if ($urandom % 300 == 0) dis_n = 0;
      if (!inh_n) begin if ($urandom % 8 == 0) inh_n = 1; end
      else if ($urandom % 100 == 0) inh_n = 0;
      hs_low = gh ? ($urandom % 8 == 0) : ($urandom % 4 != 0);
      tick();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule